// File: doc/BRIEF.md
# External Memory Port Controller

This block connects an internal request interface, which carries one 32-bit word per request, to an external system bus. The external bus has a 32-bit address and a data path that is either 32 or 64 bits wide. The width is picked by a configuration input. The block takes one request at a time. It decodes the top address field into a one-hot bank select, drives the address phase and puts the word on the correct data lane. It then finishes the access with one of two protocols, chosen per bank.

The first protocol is pipelined and synchronous. The external device returns read data a fixed number of cycles after the address phase, and that number is set per bank. The second protocol is slow. The strobe stays asserted until the device returns an acknowledge, and the access ends with one hold cycle. A watchdog counter ends a slow access that is never acknowledged and flags an error.

After every bus access, each bank inserts its own number of idle cycles, during which the data bus is released. A request whose address falls outside all banks returns an error response at once, and no bus cycle is run.

Top module: `ext_port_ctrl`

## Requirements
- R1: During a bus access, `ext_bsel_o` has exactly the bit for bank `req_addr_i[31:28]` set (banks 0 to 3). Outside an access it is all zero.
- R2: A request with `req_addr_i[31:28]` of 4 or more runs no bus cycle. In the cycle after acceptance it returns `rsp_valid_o`=1, `rsp_err_o`=1 and `rsp_rdata_o`=0, and `req_ready_o` stays high.
- R3: With `cfg_bus64_i`=0, every word uses data bits 31:0 whatever its address parity. `ext_lane_en_o`=2'b01, write data goes on `ext_data_o[31:0]` with bits 63:32 zero, and read data is taken from `ext_data_i[31:0]`.
- R4: With `cfg_bus64_i`=1, an even word address uses bits 31:0 (`ext_lane_en_o`=2'b01). An odd word address uses bits 63:32 (`ext_lane_en_o`=2'b10). On a write, the unused lane is driven with zero.
- R5: In a pipelined bank, the strobe is high for exactly one cycle, the cycle after acceptance. The depth is D = `cfg_depth_i` field + 1 (1 to 4). Read data is sampled in the cycle D cycles after the strobe cycle, and `rsp_valid_o` rises in the cycle after that. The access therefore completes D+2 cycles after acceptance.
- R6: In a slow bank, the strobe is high from the cycle after acceptance until the cycle in which `ext_ack_i` is high. Read data is sampled in that acknowledge cycle. One hold cycle follows, with the strobe low and the bank select still driven, and `rsp_valid_o` rises in the cycle after the hold cycle.
- R7: If a slow access reaches 255 strobe cycles without an acknowledge, it ends with one hold cycle. The response then has `rsp_err_o`=1 and `rsp_rdata_o`=0. An acknowledge in the 255th strobe cycle still completes the access without error.
- R8: Starting with the response cycle, `req_ready_o` stays low for I cycles, where I is the bank's `cfg_idle_i` field (0 to 3). During those cycles the strobe and `ext_data_oe_o` are low.
- R9: On a write, `ext_we_o` and `ext_data_oe_o` are high throughout the access, and `rsp_rdata_o` is 0. On a read, `ext_data_oe_o` stays low.
- R10: While `rst_ni` is low, these outputs are held at their idle values: `req_ready_o`=1, `rsp_valid_o`=0, strobe=0, `ext_data_oe_o`=0 and `ext_bsel_o`=0. This holds even when reset arrives in the middle of an access.
- R11: Protocol, depth and idle count come from the configuration fields of the addressed bank; bank b uses bit b of `cfg_slow_i` and bits [2b+1:2b] of `cfg_depth_i` and `cfg_idle_i`. The settings of other banks have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_bus64_i | input | 1 | 1 selects a 64-bit external data path |
| cfg_slow_i | input | 4 | Per-bank protocol: 1 means slow (acknowledge) protocol |
| cfg_depth_i | input | 8 | Per-bank pipeline depth minus one, 2 bits per bank |
| cfg_idle_i | input | 8 | Per-bank idle cycles after an access, 2 bits per bank |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | 32 | Word address |
| req_wdata_i | input | 32 | Write word |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_err_o | output | 1 | Unmapped address or acknowledge timeout |
| rsp_rdata_o | output | 32 | Read word |
| ext_addr_o | output | 32 | External address |
| ext_bsel_o | output | 4 | One-hot bank select |
| ext_strobe_o | output | 1 | Address/access strobe |
| ext_we_o | output | 1 | Write enable |
| ext_lane_en_o | output | 2 | Active 32-bit lanes {high, low} |
| ext_data_o | output | 64 | Write data bus |
| ext_data_oe_o | output | 1 | Data bus drive enable |
| ext_data_i | input | 64 | Read data bus |
| ext_ack_i | input | 1 | Slow-protocol acknowledge |

## Verification
The bench device model places valid read data on the bus only in the one cycle where the requirements say it is sampled, and drives garbage in every other cycle. A design that samples early or late by a single cycle, or that takes the lane of the wrong parity, therefore returns a visibly wrong word. Each bank has the opposite protocol, depth and idle settings from its neighbours, so a controller that reads the wrong bank's configuration completes at the wrong cycle. The watchdog is tested at both edges: an acknowledge in the 255th strobe cycle must succeed, and silence must end in exactly 257 cycles with an error. A mid-access reset and unmapped reads and writes confirm that the bus returns to idle and that no strobe is issued.

// File: rtl/ep_pkg.sv
package ep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PIPE,
    ST_SLOW,
    ST_HOLD,
    ST_GAP
  } ep_state_e;
endpackage

// File: rtl/ep_bank_decode.sv
module ep_bank_decode #(
  parameter int ADDR_W  = 32,
  parameter int FIELD_W = 4,
  parameter int N_BANKS = 4,
  localparam int IDX_W  = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [N_BANKS-1:0] sel_o,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [FIELD_W-1:0] field;
  assign field = addr_i[ADDR_W-1 -: FIELD_W];

  for (genvar b = 0; b < N_BANKS; b++) begin : g_sel
    assign sel_o[b] = (field == FIELD_W'(b));
  end

  assign hit_o = |sel_o;

  always_comb begin
    idx_o = '0;
    for (int b = 0; b < N_BANKS; b++)
      if (sel_o[b]) idx_o = IDX_W'(b);
  end
endmodule

// File: rtl/ep_lane_steer.sv
module ep_lane_steer #(
  parameter int WORD_W = 32,
  localparam int BUS_W = 2 * WORD_W
) (
  input  logic              bus64_i,
  input  logic              odd_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [BUS_W-1:0]  bus_rd_i,
  output logic [BUS_W-1:0]  bus_wr_o,
  output logic [1:0]        lane_en_o,
  output logic [WORD_W-1:0] rdata_o
);
  logic use_hi;
  assign use_hi    = bus64_i && odd_i;
  assign lane_en_o = use_hi ? 2'b10 : 2'b01;
  assign bus_wr_o  = use_hi ? {wdata_i, {WORD_W{1'b0}}} : {{WORD_W{1'b0}}, wdata_i};
  assign rdata_o   = use_hi ? bus_rd_i[BUS_W-1:WORD_W] : bus_rd_i[WORD_W-1:0];
endmodule

// File: rtl/ep_cycle_ctr.sv
module ep_cycle_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  // clear loads 1 so the count equals the cycle number within a phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= CNT_W'(1);
    else if (inc_i) cnt_o <= cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/ext_port_ctrl.sv
module ext_port_ctrl
  import ep_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int WORD_W  = 32,
  parameter int N_BANKS = 4,
  parameter int FIELD_W = 4,
  parameter int DEPTH_W = 2,
  parameter int IDLE_W  = 2,
  parameter int TIMEOUT = 255,
  localparam int BUS_W  = 2 * WORD_W,
  localparam int IDX_W  = (N_BANKS > 1) ? $clog2(N_BANKS) : 1,
  localparam int CNT_W  = $clog2(TIMEOUT + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cfg_bus64_i,
  input  logic [N_BANKS-1:0]         cfg_slow_i,
  input  logic [N_BANKS*DEPTH_W-1:0] cfg_depth_i,
  input  logic [N_BANKS*IDLE_W-1:0]  cfg_idle_i,
  input  logic                       req_valid_i,
  output logic                       req_ready_o,
  input  logic                       req_write_i,
  input  logic [ADDR_W-1:0]          req_addr_i,
  input  logic [WORD_W-1:0]          req_wdata_i,
  output logic                       rsp_valid_o,
  output logic                       rsp_err_o,
  output logic [WORD_W-1:0]          rsp_rdata_o,
  output logic [ADDR_W-1:0]          ext_addr_o,
  output logic [N_BANKS-1:0]         ext_bsel_o,
  output logic                       ext_strobe_o,
  output logic                       ext_we_o,
  output logic [1:0]                 ext_lane_en_o,
  output logic [BUS_W-1:0]           ext_data_o,
  output logic                       ext_data_oe_o,
  input  logic [BUS_W-1:0]           ext_data_i,
  input  logic                       ext_ack_i
);
  ep_state_e state_q, state_d;

  logic [ADDR_W-1:0]  addr_q;
  logic [WORD_W-1:0]  wdata_q;
  logic               write_q;
  logic [N_BANKS-1:0] sel_q;
  logic               slow_q;
  logic [DEPTH_W:0]   depth_q;
  logic [IDLE_W-1:0]  idle_q;
  logic               bus64_q;
  logic               rsp_valid_q, rsp_err_q;
  logic [WORD_W-1:0]  rdata_q;

  logic [N_BANKS-1:0] dec_sel;
  logic               dec_hit;
  logic [IDX_W-1:0]   dec_idx;

  logic [BUS_W-1:0]   steer_wr;
  logic [1:0]         steer_lane;
  logic [WORD_W-1:0]  steer_rd;

  logic [CNT_W-1:0]   cnt;
  logic               ctr_clr, ctr_inc;
  logic               fire, fin, cap, tout, active;

  ep_bank_decode #(
    .ADDR_W (ADDR_W),
    .FIELD_W(FIELD_W),
    .N_BANKS(N_BANKS)
  ) u_dec (
    .addr_i(req_addr_i),
    .sel_o (dec_sel),
    .hit_o (dec_hit),
    .idx_o (dec_idx)
  );

  ep_lane_steer #(.WORD_W(WORD_W)) u_steer (
    .bus64_i  (bus64_q),
    .odd_i    (addr_q[0]),
    .wdata_i  (wdata_q),
    .bus_rd_i (ext_data_i),
    .bus_wr_o (steer_wr),
    .lane_en_o(steer_lane),
    .rdata_o  (steer_rd)
  );

  ep_cycle_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (ctr_clr),
    .inc_i (ctr_inc),
    .cnt_o (cnt)
  );

  assign fire = req_valid_i && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    ctr_clr = 1'b0;
    ctr_inc = 1'b0;
    fin     = 1'b0;
    cap     = 1'b0;
    tout    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (fire && dec_hit) begin
        state_d = cfg_slow_i[dec_idx] ? ST_SLOW : ST_ADDR;
        ctr_clr = 1'b1;
      end
      ST_ADDR: begin
        state_d = ST_PIPE;
        ctr_clr = 1'b1;
      end
      ST_PIPE: begin
        if (cnt == CNT_W'(depth_q)) begin
          fin = 1'b1;
          cap = 1'b1;
        end else begin
          ctr_inc = 1'b1;
        end
      end
      ST_SLOW: begin
        if (ext_ack_i) begin
          state_d = ST_HOLD;
          cap     = 1'b1;
        end else if (cnt == CNT_W'(TIMEOUT)) begin
          state_d = ST_HOLD;
          tout    = 1'b1;
        end else begin
          ctr_inc = 1'b1;
        end
      end
      ST_HOLD: fin = 1'b1;
      ST_GAP: begin
        if (cnt == CNT_W'(idle_q)) state_d = ST_IDLE;
        else                       ctr_inc = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    if (fin) begin
      state_d = (idle_q == '0) ? ST_IDLE : ST_GAP;
      ctr_clr = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      wdata_q     <= '0;
      write_q     <= 1'b0;
      sel_q       <= '0;
      slow_q      <= 1'b0;
      depth_q     <= '0;
      idle_q      <= '0;
      bus64_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rdata_q     <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= 1'b0;
      if (fire) begin
        rdata_q <= '0;
        if (dec_hit) begin
          addr_q    <= req_addr_i;
          wdata_q   <= req_wdata_i;
          write_q   <= req_write_i;
          sel_q     <= dec_sel;
          slow_q    <= cfg_slow_i[dec_idx];
          depth_q   <= {1'b0, cfg_depth_i[dec_idx*DEPTH_W +: DEPTH_W]} + 1'b1;
          idle_q    <= cfg_idle_i[dec_idx*IDLE_W +: IDLE_W];
          bus64_q   <= cfg_bus64_i;
          rsp_err_q <= 1'b0;
        end else begin
          rsp_valid_q <= 1'b1;
          rsp_err_q   <= 1'b1;
        end
      end
      if (cap && !write_q) rdata_q <= steer_rd;
      if (tout)            rsp_err_q <= 1'b1;
      if (fin)             rsp_valid_q <= 1'b1;
    end
  end

  assign active = (state_q == ST_ADDR) || (state_q == ST_PIPE) ||
                  (state_q == ST_SLOW) || (state_q == ST_HOLD);

  assign req_ready_o   = (state_q == ST_IDLE);
  assign rsp_valid_o   = rsp_valid_q;
  assign rsp_err_o     = rsp_err_q;
  assign rsp_rdata_o   = rdata_q;
  assign ext_addr_o    = active ? addr_q : '0;
  assign ext_bsel_o    = active ? sel_q : '0;
  assign ext_strobe_o  = (state_q == ST_ADDR) || (state_q == ST_SLOW);
  assign ext_we_o      = active && write_q;
  assign ext_data_oe_o = active && write_q;
  assign ext_lane_en_o = active ? steer_lane : 2'b00;
  assign ext_data_o    = ext_data_oe_o ? steer_wr : '0;

  a_r1_bsel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ext_bsel_o));

  a_r1_strobe_has_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_strobe_o |-> ($countones(ext_bsel_o) == 1));

  a_r2_unmapped_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !dec_hit) |=> (rsp_valid_o && rsp_err_o && !ext_strobe_o));

  a_r4_single_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_data_oe_o |-> $onehot(ext_lane_en_o));

  a_r5_pipe_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_strobe_o && !slow_q) |=> !ext_strobe_o);

  a_r6_hold_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLOW && ext_ack_i) |=> (!ext_strobe_o && ext_bsel_o != '0));

  a_r8_rsp_bus_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (!ext_strobe_o && !ext_data_oe_o));
endmodule

// File: tb/tb_ext_port_ctrl.sv
module tb_ext_port_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  localparam logic [63:0] JUNK = 64'hDEAD_BEEF_0BAD_C0DE;

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wd;
    logic        b64;
    logic        slow;
    logic [1:0]  dcfg;
    logic [1:0]  idle;
    logic [8:0]  ackd;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0000_0010, 32'h0,         1'b1, 1'b0, 2'd0, 2'd0, 9'd0},
    '{1'b0, 32'h1000_0011, 32'h0,         1'b1, 1'b0, 2'd3, 2'd1, 9'd0},
    '{1'b1, 32'h2000_0005, 32'hCAFE_0001, 1'b1, 1'b0, 2'd1, 2'd2, 9'd0},
    '{1'b1, 32'h3000_0008, 32'h1234_5678, 1'b1, 1'b0, 2'd2, 2'd3, 9'd0},
    '{1'b0, 32'h0000_0007, 32'h0,         1'b0, 1'b0, 2'd2, 2'd0, 9'd0},
    '{1'b1, 32'h1000_0003, 32'h0BAD_F00D, 1'b0, 1'b0, 2'd0, 2'd1, 9'd0},
    '{1'b0, 32'h2000_0001, 32'h0,         1'b1, 1'b1, 2'd0, 2'd0, 9'd0},
    '{1'b1, 32'h3000_0002, 32'h5555_AAAA, 1'b1, 1'b1, 2'd0, 2'd2, 9'd3},
    '{1'b0, 32'h1000_0009, 32'h0,         1'b0, 1'b1, 2'd0, 2'd1, 9'd5},
    '{1'b0, 32'h0000_0004, 32'h0,         1'b1, 1'b1, 2'd0, 2'd0, 9'd254},
    '{1'b0, 32'h2000_0006, 32'h0,         1'b1, 1'b1, 2'd0, 2'd1, 9'd400},
    '{1'b0, 32'h5000_0000, 32'h0,         1'b1, 1'b0, 2'd0, 2'd0, 9'd0},
    '{1'b1, 32'hF000_0001, 32'h7777_0000, 1'b0, 1'b0, 2'd0, 2'd0, 9'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_bus64 = 1'b0;
  logic [3:0]  cfg_slow = '0;
  logic [7:0]  cfg_depth = '0;
  logic [7:0]  cfg_idle = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [63:0] ext_din = JUNK;
  logic        ext_ack = 1'b0;

  logic        req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata, ext_addr;
  logic [3:0]  ext_bsel;
  logic        ext_strobe, ext_we, ext_oe;
  logic [1:0]  ext_lane;
  logic [63:0] ext_dout;

  int checks = 0;
  int errors = 0;

  ext_port_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_bus64_i(cfg_bus64), .cfg_slow_i(cfg_slow),
    .cfg_depth_i(cfg_depth), .cfg_idle_i(cfg_idle),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .ext_addr_o(ext_addr), .ext_bsel_o(ext_bsel), .ext_strobe_o(ext_strobe),
    .ext_we_o(ext_we), .ext_lane_en_o(ext_lane), .ext_data_o(ext_dout),
    .ext_data_oe_o(ext_oe), .ext_data_i(ext_din), .ext_ack_i(ext_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input int i);
    vec_t v = VECS[i];
    int b = int'(v.addr[31:28]);
    bit mapped = (b < 4);
    int depth = int'(v.dcfg) + 1;
    bit exp_err = !mapped || (v.slow && v.ackd >= 9'd255);
    int lat = !mapped ? 1 : (v.slow ? (exp_err ? 257 : 3 + int'(v.ackd)) : depth + 2);
    int gap = mapped ? int'(v.idle) : 0;
    int exp_strb = !mapped ? 0 : (v.slow ? (exp_err ? 255 : int'(v.ackd) + 1) : 1);
    int data_k = v.slow ? 1 + int'(v.ackd) : 1 + depth;
    logic [31:0] hi = 32'hA5A5_0000 + 32'(i);
    logic [31:0] lo = 32'h5A5A_0000 + 32'(i);
    bit use_hi = v.b64 && v.addr[0];
    logic [63:0] exp_dout = (mapped && v.wr) ? (use_hi ? {v.wd, 32'h0} : {32'h0, v.wd}) : 64'h0;
    logic [31:0] exp_rd = (v.wr || exp_err) ? 32'h0 : (use_hi ? hi : lo);
    int strb = 0;
    bit early = 0;
    for (int j = 0; j < 4; j++) begin
      bit same = !mapped || (j == b);
      cfg_slow[j]        = same ? v.slow : !v.slow;
      cfg_depth[2*j +: 2] = same ? v.dcfg : ~v.dcfg;
      cfg_idle[2*j +: 2]  = same ? v.idle : ~v.idle;
    end
    cfg_bus64 = v.b64;
    req_valid = 1'b1;
    req_write = v.wr;
    req_addr  = v.addr;
    req_wdata = v.wd;
    check(req_ready == 1'b1, $sformatf("R8 ready before vec %0d", i), 64'(req_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= lat + gap; k++) begin
      ext_ack = mapped && v.slow && (k == 1 + int'(v.ackd));
      ext_din = (mapped && k == data_k) ? {hi, lo} : JUNK;
      strb += int'(ext_strobe);
      if (k == 1) begin
        check(ext_bsel == (mapped ? 4'(1 << b) : 4'h0), $sformatf("R1 bsel vec %0d", i), 64'(ext_bsel), 64'(mapped ? 4'(1 << b) : 4'h0));
        check(ext_lane == (mapped ? (use_hi ? 2'b10 : 2'b01) : 2'b00), $sformatf("R3/R4 lane vec %0d", i), 64'(ext_lane), 64'(mapped ? (use_hi ? 2'b10 : 2'b01) : 2'b00));
        check(ext_dout == exp_dout, $sformatf("R3/R4 wdata vec %0d", i), ext_dout, exp_dout);
        check(ext_we == (mapped && v.wr) && ext_oe == (mapped && v.wr), $sformatf("R9 we/oe vec %0d", i), 64'({ext_we, ext_oe}), 64'({2{mapped && v.wr}}));
        if (mapped)
          check(ext_addr == v.addr, $sformatf("R1 addr vec %0d", i), 64'(ext_addr), 64'(v.addr));
      end
      if (k < lat && rsp_valid) early = 1;
      if (mapped && k == lat - 1 && v.wr)
        check(ext_oe == 1'b1, $sformatf("R9 oe end vec %0d", i), 64'(ext_oe), 64'd1);
      if (k == lat) begin
        check(rsp_valid == 1'b1, $sformatf("R5/R6 rsp cycle vec %0d", i), 64'(rsp_valid), 64'd1);
        check(rsp_err == exp_err, $sformatf("R2/R7 err vec %0d", i), 64'(rsp_err), 64'(exp_err));
        check(rsp_rdata == exp_rd, $sformatf("R3/R4/R11 rdata vec %0d", i), 64'(rsp_rdata), 64'(exp_rd));
      end
      if (k >= lat) begin
        check(req_ready == (k >= lat + gap), $sformatf("R8 ready gap vec %0d k %0d", i, k), 64'(req_ready), 64'(k >= lat + gap));
        check(!ext_oe && !ext_strobe, $sformatf("R8 bus released vec %0d", i), 64'({ext_oe, ext_strobe}), 64'd0);
      end
      @(negedge clk);
    end
    ext_ack = 1'b0;
    ext_din = JUNK;
    check(!early, $sformatf("R5/R6 no early rsp vec %0d", i), 64'(early), 64'd0);
    check(strb == exp_strb, $sformatf("R5/R6/R7 strobe cycles vec %0d", i), 64'(strb), 64'(exp_strb));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && !ext_strobe && !ext_oe && ext_bsel == 4'h0,
          "R10 reset outputs", 64'({req_ready, rsp_valid, ext_strobe, ext_oe, ext_bsel}), 64'h80);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R10 reset in the middle of a slow write
    cfg_slow = 4'hF;
    cfg_bus64 = 1'b1;
    req_valid = 1'b1;
    req_write = 1'b1;
    req_addr = 32'h1000_0001;
    req_wdata = 32'h1111_2222;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(ext_strobe && ext_oe, "R6 strobe held without ack", 64'({ext_strobe, ext_oe}), 64'h3);
    rst_n = 1'b0;
    #1;
    check(req_ready && !rsp_valid && !ext_strobe && !ext_oe && ext_bsel == 4'h0,
          "R10 reset mid access", 64'({req_ready, rsp_valid, ext_strobe, ext_oe, ext_bsel}), 64'h80);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !ext_strobe, "R10 idle after reset", 64'({req_ready, ext_strobe}), 64'h2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule